// File: doc/BRIEF.md
# Asynchronous Strobe Register Port

This block is the slave side of a 68000-style asynchronous register bus. A host presents a 4-bit address, latches it with an active-low address strobe, selects the block with an active-low chip select and gives the direction on a read/write level. The block answers with an active-low data acknowledge. None of the bus signals share the block's clock, so every strobe passes through a two-flop synchroniser, and strobe edges are detected on the synchronised copies. The address and write data run through delay stages of the same depth, so each sample lines up with the strobe sample taken in the same cycle.

Behind the port are fourteen byte-wide registers. Twelve are configuration bytes that leave the block on a flat bus. One is a sticky error status byte that clears when it is read. One is an interrupt enable mask. Any status bit whose mask bit is set pulls the open-drain interrupt line low. The data bus is bidirectional at the pad. This block supplies the read byte, its drive enable and the sampled input byte as separate signals.

Top module: `strobe_reg_port`

## Requirements
- R1: Addresses 0 to 11 are read/write configuration bytes, and register k appears on cfg_out[8k+7:8k]. Address 12 is the read-only status byte, and a write to it is ignored. Address 13 is the read/write interrupt mask. Addresses 14 and 15 read as 0x00 and ignore writes.
- R2: The address is taken from the bus_addr sample made at the first rising clock edge that sees as_n low. Later changes to bus_addr have no effect until as_n falls again. This holds when as_n falls one clock before cs_n and when both fall in the same clock.
- R3: rd_wr high at the chip select fall selects a read and rd_wr low selects a write. A read leaves every register except status unchanged.
- R4: A write commits the bus_din value from the last clock sample taken while cs_n was low. The configuration output changes at the third rising edge after cs_n rises and at no other time.
- R5: dtack_n goes low at the third rising edge after cs_n falls, counting the first edge that samples cs_n low. It goes high again at the first edge that samples cs_n high.
- R6: bus_doe is high only during a read, over the same window in which dtack_n is low. bus_dout then holds the addressed register.
- R7: irq_pull is high exactly when some status bit and the mask bit at the same position (1 = enabled) are both set. An all-zero mask keeps it low.
- R8: Status bit i becomes set when err_evt[i] is high at a rising edge, and it stays set until status is read. A read returns the value before the clear. The clear happens at the edge where dtack_n falls, and an event sampled at that same edge leaves its bit set.
- R9: Reset clears all configuration bytes, the mask and the status. It also releases dtack_n high and drops bus_doe.
- R10: Accesses separated by only two clock cycles with cs_n high each complete correctly, including a read that follows a write to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (4) | Register address from the host |
| bus_din | input | DW (8) | Byte driven by the host on writes (pad input side) |
| bus_dout | output | DW (8) | Read byte for the pad output side |
| bus_doe | output | 1 | Pad drive enable for bus_dout |
| as_n | input | 1 | Active-low address strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |
| err_evt | input | DW (8) | Error event pulses, one per status bit |
| cfg_out | output | NUM_CFG*DW (96) | Configuration bytes, register k in byte k |

## Verification
The bench changes bus_addr one clock after the address strobe falls. A design that latched too late would write the neighbouring register. It also changes the write data in the same cycle that chip select rises, which catches a design that samples data after the strobe has gone. It counts the clocks to the acknowledge edge and to the commit edge, so a stage added to or dropped from the synchroniser shows up as a wrong count. An error event is timed to land exactly on the clearing read, which shows whether the read drops that bit. Back-to-back accesses with a two-cycle gap show whether an edge goes missing or an access runs into the one before it.

// File: rtl/strobe_reg_port.sv
module strobe_reg_port #(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int NUM_CFG = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_din,
  output logic [DW-1:0]         bus_dout,
  output logic                  bus_doe,
  input  logic                  as_n,
  input  logic                  cs_n,
  input  logic                  rd_wr,
  output logic                  dtack_n,
  output logic                  irq_pull,
  input  logic [DW-1:0]         err_evt,
  output logic [NUM_CFG*DW-1:0] cfg_out
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_CFG);
  localparam logic [AW-1:0] MASK_ADDR = AW'(NUM_CFG + 1);

  logic [2:0]    cs_sh, as_sh;
  logic [1:0]    rw_sh;
  logic [AW-1:0] a_p1, a_p2, addr_q, acc_addr, addr_sel;
  logic [DW-1:0] d_p1, d_p2, wdata_q, rdata_q, stat_q, mask_q, rd_mux;
  logic          acc_q, rd_q;
  logic          cs_fall, cs_rise, as_fall, rd_start, do_write, stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '1;
      as_sh <= '1;
      rw_sh <= '1;
      a_p1  <= '0;
      a_p2  <= '0;
      d_p1  <= '0;
      d_p2  <= '0;
    end else begin
      cs_sh <= {cs_sh[1:0], cs_n};
      as_sh <= {as_sh[1:0], as_n};
      rw_sh <= {rw_sh[0], rd_wr};
      a_p1  <= bus_addr;
      a_p2  <= a_p1;
      d_p1  <= bus_din;
      d_p2  <= d_p1;
    end
  end

  assign cs_fall  = cs_sh[2] & ~cs_sh[1];
  assign cs_rise  = ~cs_sh[2] & cs_sh[1];
  assign as_fall  = as_sh[2] & ~as_sh[1];
  assign addr_sel = as_fall ? a_p2 : addr_q;
  assign rd_start = cs_fall & rw_sh[1];
  assign do_write = cs_rise & acc_q & ~rd_q;
  assign stat_rd  = rd_start & (addr_sel == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      acc_addr <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      acc_q    <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (as_fall) addr_q <= a_p2;
      if (!cs_sh[1]) wdata_q <= d_p2;
      if (cs_fall) begin
        acc_q    <= 1'b1;
        rd_q     <= rw_sh[1];
        acc_addr <= addr_sel;
        if (rw_sh[1]) rdata_q <= rd_mux;
      end else if (cs_rise) begin
        acc_q <= 1'b0;
        rd_q  <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (do_write && acc_addr == AW'(g)) r <= wdata_q;
    end
    assign cfg_out[g*DW +: DW] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_rd ? err_evt : (stat_q | err_evt);
      if (do_write && acc_addr == MASK_ADDR) mask_q <= wdata_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CFG; k++)
      if (addr_sel == AW'(k)) rd_mux = cfg_out[k*DW +: DW];
    if (addr_sel == STAT_ADDR) rd_mux = stat_q;
    if (addr_sel == MASK_ADDR) rd_mux = mask_q;
  end

  assign dtack_n  = ~(acc_q & ~cs_sh[0]);
  assign bus_doe  = acc_q & rd_q & ~cs_sh[0];
  assign bus_dout = rdata_q;
  assign irq_pull = |(stat_q & mask_q);
endmodule

module strobe_reg_port_chk #(
  parameter int DW      = 8,
  parameter int NUM_CFG = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  rd_wr,
  input logic                  dtack_n,
  input logic                  bus_doe,
  input logic                  irq_pull,
  input logic [NUM_CFG*DW-1:0] cfg_out,
  input logic [DW-1:0]         stat_q,
  input logic [DW-1:0]         mask_q,
  input logic                  stat_rd
);
  assert_ack_within_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3)) |-> !dtack_n);

  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> dtack_n);

  assert_drive_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!$past(cs_n) && $past(rd_wr)));

  assert_cfg_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> $stable(cfg_out));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_pull);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_rd) |-> (($past(stat_q) & ~stat_q) == '0));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> (cfg_out == '0 && stat_q == '0 && mask_q == '0 && dtack_n && !bus_doe));
endmodule

bind strobe_reg_port strobe_reg_port_chk #(.DW(DW), .NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .dtack_n(dtack_n),
  .bus_doe(bus_doe), .irq_pull(irq_pull), .cfg_out(cfg_out),
  .stat_q(stat_q), .mask_q(mask_q), .stat_rd(stat_rd)
);

// File: tb/strobe_reg_port_bench.sv
module strobe_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic        as_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic        dtack_n;
  logic        irq_pull;
  logic [7:0]  err_evt = '0;
  logic [95:0] cfg_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] cfg_m [12];
  logic [7:0] mask_m = '0;
  logic [7:0] stat_m = '0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         prev_dt = 1'b1;
  bit         wd = 1'b0;

  always #2 clk = ~clk;

  strobe_reg_port u_strobe_reg_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .as_n(as_n), .cs_n(cs_n),
    .rd_wr(rd_wr), .dtack_n(dtack_n), .irq_pull(irq_pull),
    .err_evt(err_evt), .cfg_out(cfg_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [95:0] cfg_vec();
    logic [95:0] v;
    for (int k = 0; k < 12; k++) v[k*8 +: 8] = cfg_m[k];
    return v;
  endfunction

  task automatic access(input logic [3:0] a, input bit rd, input logic [7:0] d,
                        input int lead, input int hold, input int gap);
    bus_addr = a; rd_wr = rd; bus_din = d; as_n = 1'b0;
    if (lead > 0) tick(lead);
    cs_n = 1'b0;
    tick(hold);
    cs_n = 1'b1; as_n = 1'b1; bus_din = ~d;
    tick(gap);
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    if (a < 4'd12) cfg_m[a] = d;
    else if (a == 4'd13) mask_m = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    access(a, 1'b0, d, 1, 4, 3);
    model_write(a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    access(a, 1'b1, 8'h00, 1, 4, 2);
  endtask

  task automatic pulse_err(input logic [7:0] v);
    err_evt = v;
    tick(1);
    err_evt = '0;
    stat_m = stat_m | v;
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_dt && !dtack_n && bus_doe) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read drive", {88'h0, bus_dout}, 96'h0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_dout == e, t, {88'h0, bus_dout}, {88'h0, e});
      end
    end
    prev_dt = dtack_n;
  end

  task automatic run_tests();
    int n;
    for (int k = 0; k < 12; k++) cfg_m[k] = '0;
    tick(3);
    chk(dtack_n == 1'b1 && bus_doe == 1'b0, "R9 reset handshake", {94'h0, dtack_n, bus_doe}, 96'h2);
    chk(cfg_out == '0 && irq_pull == 1'b0, "R9 reset cfg/irq", cfg_out, 96'h0);
    rst_n = 1'b1;
    tick(2);
    rd(4'd6, 8'h00, "R9 cfg read after reset");
    rd(4'd13, 8'h00, "R9 mask read after reset");

    for (int k = 0; k < 12; k++) wr(4'(k), 8'(k * 37 + 5));
    chk(cfg_out == cfg_vec(), "R1 cfg_out after writes", cfg_out, cfg_vec());
    for (int k = 0; k < 12; k++) rd(4'(k), 8'(k * 37 + 5), "R1 cfg readback");

    wr(4'd14, 8'hEE);
    wr(4'd15, 8'hDD);
    wr(4'd12, 8'hFF);
    chk(cfg_out == cfg_vec(), "R1 unmapped/status write ignored", cfg_out, cfg_vec());
    rd(4'd14, 8'h00, "R1 addr 14 reads zero");
    rd(4'd15, 8'h00, "R1 addr 15 reads zero");
    rd(4'd12, 8'h00, "R1 status write ignored");

    // R5 R6: acknowledge timing on a read of register 3
    exp_q.push_back(cfg_m[3]);
    tag_q.push_back("R6 timed read data");
    bus_addr = 4'd3; rd_wr = 1'b1; as_n = 1'b0;
    tick(1);
    cs_n = 1'b0;
    n = 0;
    do begin tick(1); n++; end while (dtack_n && n < 10);
    chk(n == 3, "R5 ack fall delay", 96'(n), 96'd3);
    chk(bus_doe == 1'b1, "R6 drive during read", {95'h0, bus_doe}, 96'h1);
    tick(1);
    cs_n = 1'b1; as_n = 1'b1;
    tick(1);
    chk(dtack_n == 1'b1, "R5 ack release", {95'h0, dtack_n}, 96'h1);
    chk(bus_doe == 1'b0, "R6 release drive", {95'h0, bus_doe}, 96'h0);
    tick(2);
    chk(cfg_out == cfg_vec(), "R3 read leaves cfg", cfg_out, cfg_vec());

    // R4: commit edge and late data change
    bus_addr = 4'd5; rd_wr = 1'b0; bus_din = 8'hA5; as_n = 1'b0;
    tick(1);
    cs_n = 1'b0;
    tick(4);
    chk(cfg_out == cfg_vec(), "R4 no change while selected", cfg_out, cfg_vec());
    cs_n = 1'b1; as_n = 1'b1; bus_din = 8'h5A;
    tick(2);
    chk(cfg_out == cfg_vec(), "R4 not yet committed", cfg_out, cfg_vec());
    tick(1);
    cfg_m[5] = 8'hA5;
    chk(cfg_out == cfg_vec(), "R4 committed on third edge", cfg_out, cfg_vec());
    tick(1);

    // R2: address changed one clock after strobe fall
    bus_addr = 4'd7; rd_wr = 1'b0; bus_din = 8'h3C; as_n = 1'b0;
    tick(1);
    bus_addr = 4'd8; cs_n = 1'b0;
    tick(4);
    cs_n = 1'b1; as_n = 1'b1;
    tick(3);
    cfg_m[7] = 8'h3C;
    chk(cfg_out == cfg_vec(), "R2 address latched at strobe", cfg_out, cfg_vec());

    // R2: strobe and select fall together
    access(4'd2, 1'b0, 8'hC3, 0, 4, 3);
    cfg_m[2] = 8'hC3;
    chk(cfg_out == cfg_vec(), "R2 simultaneous strobes", cfg_out, cfg_vec());

    // R7 R8: status and interrupt
    pulse_err(8'h05);
    tick(1);
    chk(irq_pull == 1'b0, "R7 masked irq", {95'h0, irq_pull}, 96'h0);
    wr(4'd13, 8'h04);
    chk(irq_pull == 1'b1, "R7 enabled irq", {95'h0, irq_pull}, 96'h1);
    wr(4'd13, 8'h02);
    chk(irq_pull == 1'b0, "R7 other bit enabled", {95'h0, irq_pull}, 96'h0);
    wr(4'd13, 8'h04);
    rd(4'd13, 8'h04, "R1 mask readback");
    rd(4'd12, 8'h05, "R8 status read value");
    stat_m = '0;
    chk(irq_pull == 1'b0, "R8 read clears irq", {95'h0, irq_pull}, 96'h0);
    rd(4'd12, 8'h00, "R8 status cleared");

    // R8: event on the clearing edge survives
    wr(4'd13, 8'h10);
    exp_q.push_back(stat_m);
    tag_q.push_back("R8 read before same-cycle event");
    bus_addr = 4'd12; rd_wr = 1'b1; as_n = 1'b0;
    tick(1);
    cs_n = 1'b0;
    tick(2);
    err_evt = 8'h10;
    tick(1);
    err_evt = '0;
    tick(1);
    cs_n = 1'b1; as_n = 1'b1;
    tick(2);
    stat_m = 8'h10;
    chk(irq_pull == 1'b1, "R8 same-cycle event kept", {95'h0, irq_pull}, 96'h1);
    rd(4'd12, 8'h10, "R8 same-cycle bit readback");

    // R10: minimal gaps
    access(4'd9, 1'b0, 8'h66, 0, 4, 2);
    cfg_m[9] = 8'h66;
    exp_q.push_back(8'h66);
    tag_q.push_back("R10 read right after write");
    access(4'd9, 1'b1, 8'h00, 0, 4, 2);
    access(4'd10, 1'b0, 8'h77, 0, 4, 3);
    cfg_m[10] = 8'h77;
    chk(cfg_out == cfg_vec(), "R10 write after read", cfg_out, cfg_vec());
    tick(4);
  endtask

  initial begin
    fork
      run_tests();
      begin repeat (50000) @(posedge clk); wd = 1'b1; end
    join_any
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    chk(exp_q.size() == 0, "R6 reads left unanswered", 96'(exp_q.size()), 96'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule